// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a bank of hardware semaphore flags, kept apart from any memory array. Two independent ports, called A and B, use the flags to reserve shared resources. To claim a resource, a port writes zero to a flag and then reads it back. A read of zero means the flag belongs to this port. A read of one means the flag belongs to the other port or is free.

A port hands the flag back by writing one. The same write also withdraws a claim that is still waiting. A claim made while the other side holds the flag is kept as pending. When the holder lets go, the pending claim takes the flag on that same edge. If both ports claim a free flag in the same cycle, port A takes it and the claim from port B stays pending.

Each port has an active-low semaphore select and a memory chip enable. A semaphore access happens only when the select is low and the chip enable is inactive (high). A read places the flag value on every data bit and registers it. Because the value is registered, a write from the other port in that same cycle cannot alter the result.

Top module: `sem_bank_top`

## Requirements
- R1: After reset all eight flags are free and no claim is pending: both read-data outputs are all ones, and a read of any flag returns all ones on both ports.
- R2: A port performs an access only while its select is low and its chip enable is high. A write made with the select high, or with the chip enable low, leaves the flag unchanged. A read made with the chip enable low leaves the read-data output unchanged.
- R3: The flag is chosen by address bits [2:0]. All higher address bits have no effect.
- R4: After a port writes zero to a free flag, that port reads all zeros and the other port reads all ones from the same flag.
- R5: A write uses data bit 0 only. The other data bits have no effect.
- R6: A write from the port that does not hold a flag never changes what either port reads from that flag. A holder that writes one frees the flag, unless the other port has a claim pending.
- R7: A zero written by the non-holder is kept as a pending claim, and that port still reads ones. When the holder writes one, the pending port owns the flag from that edge on and reads zeros.
- R8: A non-holder that writes one withdraws its pending claim. A later release by the holder then leaves the flag free, so both ports read ones.
- R9: When both ports write zero to the same free flag in one cycle, port A owns it and port B's claim is pending. Port B becomes owner when port A releases.
- R10: Read data is registered and appears one cycle after the read is accepted. It reflects the flag state before any write in that same cycle. It keeps its value until the port's next accepted read.
- R11: Each flag is independent. An operation on one flag does not change the value read from any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_n_i | input | 1 | Port A semaphore select, active low |
| a_ce_n_i | input | 1 | Port A memory chip enable, active low (must be high for a semaphore access) |
| a_we_i | input | 1 | Port A write enable |
| a_oe_i | input | 1 | Port A output enable for reads |
| a_addr_i | input | AW | Port A address; bits [2:0] select the flag |
| a_wdata_i | input | DW | Port A write data; only bit 0 is used |
| a_rdata_o | output | DW | Port A registered read data |
| b_sel_n_i | input | 1 | Port B semaphore select, active low |
| b_ce_n_i | input | 1 | Port B memory chip enable, active low |
| b_we_i | input | 1 | Port B write enable |
| b_oe_i | input | 1 | Port B output enable for reads |
| b_addr_i | input | AW | Port B address; bits [2:0] select the flag |
| b_wdata_i | input | DW | Port B write data; only bit 0 is used |
| b_rdata_o | output | DW | Port B registered read data |

## Verification
A write changes flag state at the clock edge that accepts it, so a read issued in the next cycle already sees the change. Read data appears one edge after the read is accepted. For each read, the driver queues the expected word, and the monitor compares it at the falling edge that follows the capture edge. The hold check and the check on the ignored read sample after idle cycles, when no accepted read could have refreshed the output.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int AW      = 14,
  parameter int DW      = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel_n_i,
  input  logic               ce_n_i,
  input  logic               we_i,
  input  logic               oe_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NUM_SEM-1:0] wr_o,
  output logic               wbit_o,
  output logic               rd_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic acc;
  logic unused_bits;

  // semaphore space only while memory enable is inactive
  assign acc    = !sel_n_i && ce_n_i;
  assign idx_o  = addr_i[IDX_W-1:0];
  assign wbit_o = wdata_i[0];
  assign rd_o   = acc && !we_i && oe_i;
  assign unused_bits = ^{addr_i[AW-1:IDX_W], wdata_i[DW-1:1]};

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_wr
    assign wr_o[i] = acc && we_i && (idx_o == IDX_W'(i));
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_a_i,
  input  logic wbit_a_i,
  input  logic wr_b_i,
  input  logic wbit_b_i,
  output logic val_a_o,
  output logic val_b_o
);
  owner_e owner_q, owner_d;
  logic   req_a_q, req_b_q, req_a_d, req_b_d;

  always_comb begin
    req_a_d = wr_a_i ? ~wbit_a_i : req_a_q;
    req_b_d = wr_b_i ? ~wbit_b_i : req_b_q;
    // holder keeps while its claim stands; else A first, then B
    if (owner_q == OWN_A && req_a_d)      owner_d = OWN_A;
    else if (owner_q == OWN_B && req_b_d) owner_d = OWN_B;
    else if (req_a_d)                     owner_d = OWN_A;
    else if (req_b_d)                     owner_d = OWN_B;
    else                                  owner_d = OWN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      req_a_q <= 1'b0;
      req_b_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      req_a_q <= req_a_d;
      req_b_q <= req_b_d;
    end
  end

  assign val_a_o = (owner_q != OWN_A);
  assign val_b_o = (owner_q != OWN_B);

  p_owner_has_claim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owner_q == OWN_A) -> req_a_q) && ((owner_q == OWN_B) -> req_b_q));

  p_grant_on_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_A && wr_a_i && wbit_a_i && !wr_b_i && req_b_q) |=> owner_q == OWN_B);

  p_holder_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_B && !wr_b_i) |=> owner_q == OWN_B);

  p_cancel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_A && wr_b_i && wbit_b_i) |=> !req_b_q);

  p_tie_left_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && wr_a_i && !wbit_a_i && wr_b_i && !wbit_b_i)
    |=> (owner_q == OWN_A && req_b_q));
endmodule

// File: rtl/sem_rd_latch.sv
module sem_rd_latch #(
  parameter int DW      = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_SEM-1:0] vals_i,
  output logic [DW-1:0]      rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '1;
    else if (rd_i) rdata_o <= {DW{vals_i[idx_i]}};
  end

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_rd_uniform_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o == '0) || (rdata_o == '1));
endmodule

// File: rtl/sem_bank_top.sv
module sem_bank_top #(
  parameter int AW      = 14,
  parameter int DW      = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_sel_n_i,
  input  logic          a_ce_n_i,
  input  logic          a_we_i,
  input  logic          a_oe_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_sel_n_i,
  input  logic          b_ce_n_i,
  input  logic          b_we_i,
  input  logic          b_oe_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [NUM_SEM-1:0] wr_a, wr_b, val_a, val_b;
  logic               wbit_a, wbit_b, rd_a, rd_b;
  logic [IDX_W-1:0]   idx_a, idx_b;

  sem_port_dec #(.AW(AW), .DW(DW), .NUM_SEM(NUM_SEM)) u_dec_a (
    .sel_n_i(a_sel_n_i), .ce_n_i(a_ce_n_i), .we_i(a_we_i), .oe_i(a_oe_i),
    .addr_i(a_addr_i), .wdata_i(a_wdata_i),
    .wr_o(wr_a), .wbit_o(wbit_a), .rd_o(rd_a), .idx_o(idx_a)
  );

  sem_port_dec #(.AW(AW), .DW(DW), .NUM_SEM(NUM_SEM)) u_dec_b (
    .sel_n_i(b_sel_n_i), .ce_n_i(b_ce_n_i), .we_i(b_we_i), .oe_i(b_oe_i),
    .addr_i(b_addr_i), .wdata_i(b_wdata_i),
    .wr_o(wr_b), .wbit_o(wbit_b), .rd_o(rd_b), .idx_o(idx_b)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    sem_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_a_i(wr_a[i]), .wbit_a_i(wbit_a),
      .wr_b_i(wr_b[i]), .wbit_b_i(wbit_b),
      .val_a_o(val_a[i]), .val_b_o(val_b[i])
    );
  end

  sem_rd_latch #(.DW(DW), .NUM_SEM(NUM_SEM)) u_rd_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_a), .idx_i(idx_a),
    .vals_i(val_a), .rdata_o(a_rdata_o)
  );

  sem_rd_latch #(.DW(DW), .NUM_SEM(NUM_SEM)) u_rd_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_b), .idx_i(idx_b),
    .vals_i(val_b), .rdata_o(b_rdata_o)
  );

  // a flag is never read as owned by both ports
  p_single_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_a | val_b) == '1);
endmodule

// File: tb/sim_sem_bank_top.sv
`timescale 1ns/1ps
module sim_sem_bank_top;
  localparam int AW = 14;
  localparam int DW = 8;
  localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2;

  typedef struct {
    logic [DW-1:0] e;
    string         t;
  } exp_t;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          a_sel_n = 1'b1, a_ce_n = 1'b1, a_we = 1'b0, a_oe = 1'b0;
  logic [AW-1:0] a_addr = '0;
  logic [DW-1:0] a_wdata = '0;
  logic          b_sel_n = 1'b1, b_ce_n = 1'b1, b_we = 1'b0, b_oe = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          mon_a, mon_b;
  int            n_cmp = 0, n_bad = 0, junk = 1;
  bit            done = 1'b0;
  exp_t          qa[$], qb[$];

  always #10 clk = ~clk;

  sem_bank_top #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_sel_n_i(a_sel_n), .a_ce_n_i(a_ce_n), .a_we_i(a_we), .a_oe_i(a_oe),
    .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_rdata_o(a_rdata),
    .b_sel_n_i(b_sel_n), .b_ce_n_i(b_ce_n), .b_we_i(b_we), .b_oe_i(b_oe),
    .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_rdata_o(b_rdata)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side record of accepted reads, result due one edge later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_a <= 1'b0;
      mon_b <= 1'b0;
    end else begin
      mon_a <= !a_sel_n && a_ce_n && !a_we && a_oe;
      mon_b <= !b_sel_n && b_ce_n && !b_we && b_oe;
    end
  end

  always @(negedge clk) begin : mon_blk
    exp_t x;
    if (mon_a) begin
      if (qa.size() == 0) chk("port A unexpected read", a_rdata, 'x);
      else begin x = qa.pop_front(); chk(x.t, a_rdata, x.e); end
    end
    if (mon_b) begin
      if (qb.size() == 0) chk("port B unexpected read", b_rdata, 'x);
      else begin x = qb.pop_front(); chk(x.t, b_rdata, x.e); end
    end
  end

  // addresses carry varying upper bits (R3); write data toggles bits 7:1 against bit 0 (R5)
  task automatic step(input int oa, input int ia, input bit da, input bit ea, input string ta,
                      input int ob, input int ib, input bit db, input bit eb, input string tb);
    exp_t x;
    junk = (junk * 37 + 11) % 2048;
    a_sel_n = (oa == OP_IDLE); a_ce_n = 1'b1; a_we = (oa == OP_WR); a_oe = (oa == OP_RD);
    a_addr  = AW'(ia) | AW'(junk << 3);
    a_wdata = da ? 8'h01 : 8'hFE;
    b_sel_n = (ob == OP_IDLE); b_ce_n = 1'b1; b_we = (ob == OP_WR); b_oe = (ob == OP_RD);
    b_addr  = AW'(ib) | AW'((junk ^ 12'h5A5) << 3);
    b_wdata = db ? 8'h01 : 8'hFE;
    if (oa == OP_RD) begin x.e = ea ? 8'hFF : 8'h00; x.t = {"A ", ta}; qa.push_back(x); end
    if (ob == OP_RD) begin x.e = eb ? 8'hFF : 8'h00; x.t = {"B ", tb}; qb.push_back(x); end
    @(negedge clk);
    a_sel_n = 1'b1; a_we = 1'b0; a_oe = 1'b0;
    b_sel_n = 1'b1; b_we = 1'b0; b_oe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("A R1 reset", a_rdata, 8'hFF);
    chk("B R1 reset", b_rdata, 8'hFF);
    for (int i = 0; i < 8; i++) step(OP_RD, i, 0, 1, "R1", OP_RD, i, 0, 1, "R1");

    // R4 R5: A claims free flag 2
    step(OP_WR, 2, 0, 0, "", OP_IDLE, 0, 0, 0, "");
    step(OP_RD, 2, 0, 0, "R4 R5", OP_RD, 2, 0, 1, "R4 R3");
    // R6: non-holder writes one, nothing changes
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 2, 1, 0, "");
    step(OP_RD, 2, 0, 0, "R6", OP_RD, 2, 0, 1, "R6");
    // R7: B claim pends, granted on release
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 2, 0, 0, "");
    step(OP_RD, 2, 0, 0, "R7 holder", OP_RD, 2, 0, 1, "R7 pending");
    step(OP_WR, 2, 1, 0, "", OP_IDLE, 0, 0, 0, "");
    step(OP_RD, 2, 0, 1, "R7 released", OP_RD, 2, 0, 0, "R7 granted");
    // R8: A claims then cancels, B releases, flag free
    step(OP_WR, 2, 0, 0, "", OP_IDLE, 0, 0, 0, "");
    step(OP_WR, 2, 1, 0, "", OP_IDLE, 0, 0, 0, "");
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 2, 1, 0, "");
    step(OP_RD, 2, 0, 1, "R8", OP_RD, 2, 0, 1, "R8");
    // R9: tie on free flag 5
    step(OP_WR, 5, 0, 0, "", OP_WR, 5, 0, 0, "");
    step(OP_RD, 5, 0, 0, "R9 winner", OP_RD, 5, 0, 1, "R9 loser");
    step(OP_WR, 5, 1, 0, "", OP_IDLE, 0, 0, 0, "");
    step(OP_RD, 5, 0, 1, "R9 released", OP_RD, 5, 0, 0, "R9 pending granted");
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 5, 1, 0, "");
    step(OP_RD, 5, 0, 1, "R9 free", OP_RD, 5, 0, 1, "R9 free");
    // R10: B reads in the same cycle A releases; sees pre-write state
    step(OP_WR, 3, 0, 0, "", OP_IDLE, 0, 0, 0, "");
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 3, 0, 0, "");
    step(OP_WR, 3, 1, 0, "", OP_RD, 3, 0, 1, "R10 same-cycle");
    step(OP_IDLE, 0, 0, 0, "", OP_RD, 3, 0, 0, "R10 after");
    idle(3);
    chk("B R10 hold", b_rdata, 8'h00);
    chk("A R10 hold", a_rdata, 8'hFF);
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 3, 1, 0, "");
    // R2: writes with chip enable low or select high are ignored
    a_sel_n = 1'b0; a_ce_n = 1'b0; a_we = 1'b1; a_addr = 14'd6; a_wdata = 8'h00;
    @(negedge clk);
    a_sel_n = 1'b1; a_ce_n = 1'b1;
    b_sel_n = 1'b1; b_ce_n = 1'b1; b_we = 1'b1; b_addr = 14'd6; b_wdata = 8'h00;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    step(OP_RD, 6, 0, 1, "R2 write ignored", OP_RD, 6, 0, 1, "R2 write ignored");
    // R2: A owns flag 0; read with chip enable low must not refresh output
    step(OP_WR, 0, 0, 0, "", OP_IDLE, 0, 0, 0, "");
    a_sel_n = 1'b0; a_ce_n = 1'b0; a_oe = 1'b1; a_addr = 14'd0;
    @(negedge clk);
    a_sel_n = 1'b1; a_ce_n = 1'b1; a_oe = 1'b0;
    @(negedge clk);
    chk("A R2 read ignored", a_rdata, 8'hFF);
    // R11: independent flags
    step(OP_IDLE, 0, 0, 0, "", OP_WR, 7, 0, 0, "");
    step(OP_RD, 0, 0, 0, "R11", OP_RD, 0, 0, 1, "R11");
    step(OP_RD, 7, 0, 1, "R11", OP_RD, 7, 0, 0, "R11");
    step(OP_RD, 1, 0, 1, "R11", OP_RD, 1, 0, 1, "R11");
    step(OP_RD, 6, 0, 1, "R11 R3", OP_RD, 2, 0, 1, "R11");
    idle(3);
    if (qa.size() != 0 || qb.size() != 0) chk("queue drain", 8'(qa.size() + qb.size()), 8'h00);
    finish_run();
  end
endmodule